// File: doc/BRIEF.md
# Programmable Chip-Select Generator with Strap Configuration

This unit decodes each bus cycle on a 24-bit address bus into a set of active-low select lines. There is one boot select (index 0) and eleven general selects (indices 1 to 11). Each select has three things software can write: a base word (base address plus block size), an option word (byte enable, direction and address space) and a two-bit pin field. The upper pin bit gives the pin to the select function. The lower pin bit of the boot select gives the width of the boot port.

While reset is held, the unit reads strap levels from the low byte of the data bus into the pin fields. The boot select leaves reset enabled and mapped at address zero, so the first instruction fetch finds the boot memory. Every general select stays silent until software gives it a byte enable and a direction. After reset the selects are reprogrammed through a one-cycle register write port.

Top module: `cs_unit`

## Requirements
- R1: After reset the boot select covers the 1 Mbyte window from address 0x000000 to 0x0FFFFF for reads and writes in user and supervisor space. It does not assert at 0x100000 or above.
- R2: boot_port16 takes the level of strap bit 0 as sampled on the last clock edge with rst_n low (1 = 16-bit, 0 = 8-bit). Strap changes after reset leave it unchanged.
- R3: After reset no general select asserts, because its byte field resets to 00 (disable) and its direction field resets to 00 (never).
- R4: The upper pin bit of general select g resets to strap bit 1+((g-1) mod 7). The boot select's upper pin bit resets to 1. A select whose upper pin bit is 0 never asserts.
- R5: A select matches when the address bits at and above its block size equal the same bits of base×2048. Size codes 0 to 7 mean 2K, 8K, 16K, 64K, 128K, 256K, 512K and 1M bytes.
- R6: Direction field: 00 never matches, 01 matches reads only (bus_rd=1), 10 matches writes only, 11 matches both.
- R7: Space field: 00 matches only CPU-space cycles (bus_cpu=1). 01 matches user cycles, 10 matches supervisor cycles and 11 matches either. Fields 01 to 11 never match a CPU-space cycle.
- R8: cs_n is registered. A select goes low on the first clock edge at which bus_strobe and a match are both sampled. It returns high on the first edge at which bus_strobe is sampled low.
- R9: A write with wr_en=1 updates the select named by wr_sel according to wr_kind. Kind 0 loads the base word: data[15:3] is the base and data[2:0] the size. Kind 1 loads the option word: data[15:14] byte, data[13:12] direction, data[11:10] space. Kind 2 loads the pin field from data[1:0]. Kind 3, or a wr_sel above 11, changes nothing.
- R10: A byte field of 00 blocks the select. Codes 01, 10 and 11 enable it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap | input | 8 | Data-bus strap levels read during reset |
| bus_addr | input | 24 | Bus cycle address |
| bus_strobe | input | 1 | Bus cycle in progress |
| bus_rd | input | 1 | 1 for read, 0 for write |
| bus_super | input | 1 | 1 for a supervisor cycle |
| bus_cpu | input | 1 | 1 for a CPU-space cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Select index to write |
| wr_kind | input | 2 | 0 base, 1 option, 2 pin, 3 none |
| wr_data | input | 16 | Write data |
| cs_n | output | 12 | Active-low selects, bit 0 is boot |
| boot_port16 | output | 1 | Boot port width, 1 means 16 bits |

## Verification
The hardest state to reach from the ports is the strap-derived pin configuration of the general selects. It cannot be seen until a select is fully programmed, and strap bits are shared between several selects. The bench resets under two different strap patterns. After each reset it enables every general select in its own disjoint window and probes each window. A select whose strap bit was low must stay silent even though its registers would match. Block sizes, directions and spaces are swept exhaustively over one select, at the window edges.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;
  localparam int ADDR_W   = 24;
  localparam int BASE_LSB = 11;
  localparam int BASE_W   = ADDR_W - BASE_LSB;
  localparam int STRAP_W  = 8;

  typedef enum logic [1:0] {
    WK_BASE = 2'd0,
    WK_OPT  = 2'd1,
    WK_PIN  = 2'd2,
    WK_NONE = 2'd3
  } wr_kind_e;

  // number of low address bits ignored by a block-size code
  function automatic int unsigned blk_shift(input logic [2:0] sz);
    case (sz)
      3'd0:    return 11;
      3'd1:    return 13;
      3'd2:    return 14;
      3'd3:    return 16;
      3'd4:    return 17;
      3'd5:    return 18;
      3'd6:    return 19;
      default: return 20;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [ADDR_W-1:0] a,
                                    input logic [BASE_W-1:0] b,
                                    input logic [2:0] sz);
    logic [ADDR_W-1:0] diff;
    diff = a ^ {b, {BASE_LSB{1'b0}}};
    return (diff >> blk_shift(sz)) == '0;
  endfunction

  function automatic logic dir_hit(input logic [1:0] rw, input logic rd);
    case (rw)
      2'b01:   return rd;
      2'b10:   return !rd;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic space_hit(input logic [1:0] sp, input logic sup,
                                     input logic cpu);
    if (cpu) return sp == 2'b00;
    return (sp == 2'b11) || (sp == 2'b10 && sup) || (sp == 2'b01 && !sup);
  endfunction

  // strap bit that configures general select g (g >= 1)
  function automatic int strap_index(input int g);
    return 1 + ((g - 1) % 7);
  endfunction
endpackage

// File: rtl/cs_regs.sv
`timescale 1ns/1ps
module cs_regs
  import cs_pkg::*;
#(
  parameter int NUM_SEL = 12,
  parameter int SEL_W   = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [STRAP_W-1:0]                strap,
  input  logic                              wr_en,
  input  logic [SEL_W-1:0]                  wr_sel,
  input  logic [1:0]                        wr_kind,
  input  logic [15:0]                       wr_data,
  output logic [NUM_SEL-1:0][BASE_W-1:0]    base_o,
  output logic [NUM_SEL-1:0][2:0]           size_o,
  output logic [NUM_SEL-1:0][1:0]           byte_o,
  output logic [NUM_SEL-1:0][1:0]           rw_o,
  output logic [NUM_SEL-1:0][1:0]           sp_o,
  output logic [NUM_SEL-1:0][1:0]           pin_o
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    localparam logic [2:0] RST_SIZE = (i == 0) ? 3'd7 : 3'd0;
    localparam logic [1:0] RST_EN   = (i == 0) ? 2'b11 : 2'b00;
    logic pin_hi_rst, pin_lo_rst, sel_wr;

    if (i == 0) begin : g_boot
      assign pin_hi_rst = 1'b1;
      assign pin_lo_rst = strap[0];
    end else begin : g_gen
      localparam int SB = strap_index(i);
      assign pin_hi_rst = strap[SB];
      assign pin_lo_rst = 1'b0;
    end

    assign sel_wr = wr_en && (wr_sel == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_o[i] <= '0;
        size_o[i] <= RST_SIZE;
        byte_o[i] <= RST_EN;
        rw_o[i]   <= RST_EN;
        sp_o[i]   <= RST_EN;
        pin_o[i]  <= {pin_hi_rst, pin_lo_rst};
      end else if (sel_wr) begin
        case (wr_kind_e'(wr_kind))
          WK_BASE: begin
            base_o[i] <= wr_data[15:3];
            size_o[i] <= wr_data[2:0];
          end
          WK_OPT: begin
            byte_o[i] <= wr_data[15:14];
            rw_o[i]   <= wr_data[13:12];
            sp_o[i]   <= wr_data[11:10];
          end
          WK_PIN:  pin_o[i] <= wr_data[1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cs_match.sv
`timescale 1ns/1ps
module cs_match
  import cs_pkg::*;
(
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_super,
  input  logic              bus_cpu,
  input  logic [BASE_W-1:0] base,
  input  logic [2:0]        size,
  input  logic              enabled,
  input  logic [1:0]        rw,
  input  logic [1:0]        sp,
  output logic              hit
);
  logic a_ok, d_ok, s_ok;
  assign a_ok = addr_hit(bus_addr, base, size);
  assign d_ok = dir_hit(rw, bus_rd);
  assign s_ok = space_hit(sp, bus_super, bus_cpu);
  assign hit  = enabled && a_ok && d_ok && s_ok;
endmodule

// File: rtl/cs_unit.sv
`timescale 1ns/1ps
module cs_unit
  import cs_pkg::*;
#(
  parameter int NUM_GEN = 11,
  localparam int NUM_SEL = NUM_GEN + 1,
  localparam int SEL_W   = $clog2(NUM_SEL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         strap,
  input  logic [23:0]        bus_addr,
  input  logic               bus_strobe,
  input  logic               bus_rd,
  input  logic               bus_super,
  input  logic               bus_cpu,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [1:0]         wr_kind,
  input  logic [15:0]        wr_data,
  output logic [NUM_SEL-1:0] cs_n,
  output logic               boot_port16
);
  logic [NUM_SEL-1:0][BASE_W-1:0] base_v;
  logic [NUM_SEL-1:0][2:0]        size_v;
  logic [NUM_SEL-1:0][1:0]        byte_v, rw_v, sp_v, pin_v;
  logic [NUM_SEL-1:0]             hit_v, pin_cs, byte_en;

  cs_regs #(.NUM_SEL(NUM_SEL), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap(strap),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_kind(wr_kind), .wr_data(wr_data),
    .base_o(base_v), .size_o(size_v), .byte_o(byte_v),
    .rw_o(rw_v), .sp_o(sp_v), .pin_o(pin_v)
  );

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_dec
    assign pin_cs[i]  = pin_v[i][1];
    assign byte_en[i] = |byte_v[i];
    cs_match u_match (
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_super(bus_super),
      .bus_cpu(bus_cpu), .base(base_v[i]), .size(size_v[i]),
      .enabled(pin_cs[i] && byte_en[i]), .rw(rw_v[i]), .sp(sp_v[i]),
      .hit(hit_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cs_n <= '1;
    else        cs_n <= ~(hit_v & {NUM_SEL{bus_strobe}});
  end

  assign boot_port16 = pin_v[0][0];
endmodule

// File: rtl/cs_unit_chk.sv
`timescale 1ns/1ps
module cs_unit_chk #(
  parameter int NUM_SEL = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_strobe,
  input logic               wr_en,
  input logic               strap0,
  input logic               boot_port16,
  input logic [NUM_SEL-1:0] cs_n,
  input logic [NUM_SEL-1:0] pin_cs,
  input logic [NUM_SEL-1:0] byte_en
);
  assert_width_from_strap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> boot_port16 == $past(strap0));

  assert_width_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_en) |-> $stable(boot_port16));

  assert_boot_live_at_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pin_cs[0] && byte_en[0]);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assert_select_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> $past(bus_strobe));
    assert_select_needs_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> $past(byte_en[i]));
    assert_select_needs_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n[i] |-> $past(pin_cs[i]));
  end
endmodule

bind cs_unit cs_unit_chk #(.NUM_SEL(NUM_SEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .wr_en(wr_en),
  .strap0(strap[0]), .boot_port16(boot_port16), .cs_n(cs_n),
  .pin_cs(pin_cs), .byte_en(byte_en)
);

// File: tb/tb_cs_unit.sv
`timescale 1ns/1ps
module tb_cs_unit;
  localparam int NS = 12;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] strap = 8'hFF;
  logic [23:0] bus_addr = '0;
  logic bus_strobe = 0, bus_rd = 0, bus_super = 0, bus_cpu = 0;
  logic wr_en = 0;
  logic [3:0] wr_sel = '0;
  logic [1:0] wr_kind = '0;
  logic [15:0] wr_data = '0;
  logic [NS-1:0] cs_n;
  logic boot_port16;

  cs_unit dut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .bus_addr(bus_addr),
    .bus_strobe(bus_strobe), .bus_rd(bus_rd), .bus_super(bus_super),
    .bus_cpu(bus_cpu), .wr_en(wr_en), .wr_sel(wr_sel), .wr_kind(wr_kind),
    .wr_data(wr_data), .cs_n(cs_n), .boot_port16(boot_port16)
  );

  int checks = 0, errs = 0;
  bit done = 0;
  int blk_bytes [8] = '{2048, 8192, 16384, 65536, 131072, 262144, 524288, 1048576};
  int m_base [NS], m_size [NS], m_byte [NS], m_rw [NS], m_sp [NS], m_pin [NS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_vec(int a, bit rd, bit sup, bit cpu);
    logic [NS-1:0] v;
    for (int i = 0; i < NS; i++) begin
      int blk = blk_bytes[m_size[i]];
      bit am = (a / blk) == ((m_base[i] * 2048) / blk);
      bit dm = (m_rw[i] == 3) || (m_rw[i] == 1 && rd) || (m_rw[i] == 2 && !rd);
      bit sm = cpu ? (m_sp[i] == 0)
                   : ((m_sp[i] == 3) || (m_sp[i] == 2 && sup) || (m_sp[i] == 1 && !sup));
      bit en = (m_byte[i] != 0) && (m_pin[i] >= 2);
      v[i] = !(am && dm && sm && en);
    end
    return v;
  endfunction

  task automatic do_reset(input logic [7:0] s);
    @(negedge clk);
    rst_n = 0; strap = s; bus_strobe = 0; wr_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NS; i++) begin
      m_base[i] = 0;
      m_size[i] = (i == 0) ? 7 : 0;
      m_byte[i] = (i == 0) ? 3 : 0;
      m_rw[i]   = (i == 0) ? 3 : 0;
      m_sp[i]   = (i == 0) ? 3 : 0;
      if (i == 0) m_pin[i] = 2 + int'(s[0]);
      else        m_pin[i] = s[1 + ((i - 1) % 7)] ? 2 : 0;
    end
  endtask

  task automatic wr(input int sel, input int kind, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = 4'(sel); wr_kind = 2'(kind); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (sel < NS) begin
      case (kind)
        0: begin m_base[sel] = int'(d[15:3]); m_size[sel] = int'(d[2:0]); end
        1: begin m_byte[sel] = int'(d[15:14]); m_rw[sel] = int'(d[13:12]);
                 m_sp[sel] = int'(d[11:10]); end
        2: m_pin[sel] = int'(d[1:0]);
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input int a, input bit rd, input bit sup, input bit cpu,
                     input string req);
    logic [NS-1:0] e;
    e = exp_vec(a, rd, sup, cpu);
    @(negedge clk);
    bus_addr = 24'(a); bus_rd = rd; bus_super = sup; bus_cpu = cpu; bus_strobe = 1;
    @(negedge clk);
    chk(cs_n === e, req, int'(cs_n), int'(e));
    bus_strobe = 0;
    @(negedge clk);
    chk(cs_n === '1, "R8 release", int'(cs_n), 'hFFF);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    // first reset: 8-bit boot port, sparse general straps
    do_reset(8'h54);
    @(negedge clk);
    chk(cs_n === '1, "R8 reset idle", int'(cs_n), 'hFFF);
    chk(boot_port16 === 1'b0, "R2 strap low", int'(boot_port16), 0);
    strap = 8'hFF;
    repeat (3) @(negedge clk);
    chk(boot_port16 === 1'b0, "R2 hold", int'(boot_port16), 0);

    // R1 / R3: boot window at reset, general selects silent
    foreach (blk_bytes[k]) begin
      int a = (k < 4) ? blk_bytes[k] - 1 : 24'h100000 + blk_bytes[k];
      cyc(a, 1, 1, 0, "R1 R3 sup read");
      cyc(a, 0, 0, 0, "R1 R3 user write");
    end
    cyc(0, 1, 1, 0, "R1 zero");
    cyc(24'h0FFFFF, 1, 0, 0, "R1 top");
    cyc(24'h100000, 1, 1, 0, "R1 beyond");
    cyc(24'hFFFFFF, 0, 1, 0, "R1 end");

    // R4: enable every general select in its own 128K window
    for (int g = 1; g < NS; g++) begin
      wr(g, 0, 16'((g << 6) << 3));
      wr(g, 1, 16'hFC00);
    end
    for (int g = 1; g < NS; g++) begin
      cyc(g * 131072, 1, 1, 0, "R4 strap pin");
      cyc(g * 131072 + 2047, 0, 0, 0, "R4 strap pin top");
    end

    // second reset with all straps high
    do_reset(8'hFF);
    @(negedge clk);
    chk(boot_port16 === 1'b1, "R2 strap high", int'(boot_port16), 1);
    for (int g = 1; g < NS; g++) begin
      wr(g, 0, 16'((g << 6) << 3));
      wr(g, 1, 16'hFC00);
      cyc(g * 131072 + 100, 1, 1, 0, "R4 R9 all pins");
    end
    for (int g = 1; g < NS; g++) wr(g, 1, 16'h0000);

    // R5: every block size on select 1 at 0x300000
    for (int sz = 0; sz < 8; sz++) begin
      wr(1, 0, 16'(((24'h300000 >> 11) << 3) | sz));
      wr(1, 1, 16'hFC00);
      cyc(24'h300000, 1, 1, 0, "R5 base");
      cyc(24'h300000 + blk_bytes[sz] - 1, 1, 1, 0, "R5 last");
      cyc(24'h300000 + blk_bytes[sz], 1, 1, 0, "R5 past");
      cyc(24'h2FFFFF, 1, 1, 0, "R5 below");
    end

    // R6 / R7 / R10 on select 2 at 0x400000
    wr(2, 0, 16'((24'h400000 >> 11) << 3));
    for (int rw = 0; rw < 4; rw++) begin
      wr(2, 1, 16'((3 << 14) | (rw << 12) | (3 << 10)));
      cyc(24'h400010, 1, 1, 0, "R6 read");
      cyc(24'h400010, 0, 1, 0, "R6 write");
    end
    for (int sp = 0; sp < 4; sp++) begin
      wr(2, 1, 16'((3 << 14) | (3 << 12) | (sp << 10)));
      for (int c = 0; c < 4; c++) cyc(24'h400020, 1, c[0], c[1], "R7 space");
    end
    for (int b = 0; b < 4; b++) begin
      wr(2, 1, 16'((b << 14) | (3 << 12) | (3 << 10)));
      cyc(24'h400030, 0, 1, 0, "R10 byte");
    end

    // R9: ignored writes, pin writes
    wr(2, 1, 16'h0000);
    wr(2, 3, 16'hFFFF);
    wr(3, 1, 16'hFC00);
    wr(13, 1, 16'hFC00);
    cyc(24'h400030, 0, 1, 0, "R9 ignored");
    wr(2, 1, 16'hFC00);
    wr(2, 2, 16'h0000);
    cyc(24'h400030, 1, 1, 0, "R4 R9 pin off");
    wr(0, 2, 16'h0002);
    @(negedge clk);
    chk(boot_port16 === 1'b0, "R9 boot width write", int'(boot_port16), 0);
    cyc(24'h000100, 1, 1, 0, "R9 boot still on");
    wr(0, 2, 16'h0000);
    cyc(24'h000100, 1, 1, 0, "R4 boot pin off");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule